// File: doc/BRIEF.md
# Thread Interrupt Priority Presenter

This block holds the interrupt presentation state of one hardware thread. The state is split into three rings: a guest operating-system ring, a hypervisor pool ring and a hypervisor physical ring. Each ring has an 8-bit pending buffer with one bit per priority. Only the OS and physical rings are signalling rings. Each signalling ring keeps three registers: a current processor priority (CPPR), a pending interrupt priority (PIPR) and a notification status byte (NSR). The pool ring has no signalling registers. Its exceptions are raised through the physical ring's registers, and the top two NSR bits record which hypervisor ring the exception belongs to. Priority 0 is the most favoured and 7 is the least favoured.

Three request ports drive the block, and each one is a single-cycle strobe. A presentation delivers a priority and a group level to a ring. An acknowledge takes the pending exception of a signalling ring and returns its status. A CPPR write changes a signalling ring's threshold and re-evaluates its pending work. Each cycle a small operation selector picks one of four operations: OP_IDLE, OP_ACK, OP_CPPR or OP_PRESENT. The choice is fixed: an acknowledge wins over a CPPR write, and a CPPR write wins over a presentation. Requests that lose are dropped. Every operation completes in the cycle it is selected, so the selector returns to OP_IDLE or to the next granted operation on the following edge. There is no multi-cycle sequencing. The block drives one exception output per signalling ring, and this output is high exactly when that ring's NSR reports an exception.

Top module: `thread_irq_presenter`

## Requirements
- R1: After reset, all pending buffers and NSRs are 0x00, both CPPRs are 0x00, both PIPRs are 0xFF, both exception outputs are low and the acknowledge data is 0x0000.
- R2: Priority p maps to pending-buffer bit 7-p (mask 0x80 >> p). A presentation with group level 0 always sets that bit in the target ring, even when the presentation goes no further.
- R3: A presentation with group level 0 changes the signalling ring's PIPR and NSR only when its priority is strictly lower than that ring's current PIPR. Otherwise only the buffer bit changes.
- R4: When a presentation updates PIPR, an exception is raised only if the new PIPR is strictly lower than CPPR. If it is not, NSR is cleared and the output goes low.
- R5: NSR encoding is as follows. On the OS ring, NSR is 0x80 ORed with the group level in bits 5:0. On the physical ring, bits 7:6 are 2'b10 for a physical exception and 2'b01 for a pool exception, and bits 5:0 hold the group level. The code 2'b11 never occurs.
- R6: A presentation to the pool ring (ring code 1) sets the pool buffer bit but is signalled through the physical ring's CPPR, PIPR, NSR and output.
- R7: A presentation with a non-zero group level leaves every pending buffer unchanged. It loads PIPR with its priority unconditionally, then applies R4.
- R8: An acknowledge with an exception pending does the following. It loads CPPR from PIPR. If the NSR group level is 0, it clears the bit for that priority in the ring that NSR selects (OS, pool or physical). It clears NSR and lowers the output. One cycle later it shows {old NSR, new CPPR} on the 16-bit acknowledge data.
- R9: An acknowledge with no exception pending changes no state and returns {NSR, CPPR} as they stand.
- R10: A CPPR write with a value above 7 stores 0xFF. The write then recomputes PIPR as the most favoured set bit of the ring's own buffer (0xFF if the buffer is empty) and re-runs the R4 exception check with group level 0.
- R11: On a physical CPPR write with the pool context valid input high, the pool buffer's best priority replaces the physical one only if it is strictly lower, and the exception is then coded as pool. When the valid input is low, the pool buffer is ignored.
- R12: Only one operation runs per cycle, chosen in the order acknowledge, then CPPR write, then presentation. A presentation with ring code 3 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pool_ctx_valid | input | 1 | Pool context valid flag, used by physical CPPR writes |
| pres_valid | input | 1 | Presentation strobe |
| pres_ring | input | 2 | Target ring: 0 OS, 1 pool, 2 physical, 3 reserved |
| pres_prio | input | 3 | Presentation priority |
| pres_group | input | 6 | Group level, 0 for a specific target |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_sel | input | 1 | Acknowledged ring: 0 OS, 1 physical |
| cppr_wr_valid | input | 1 | CPPR write strobe |
| cppr_wr_sel | input | 1 | Written ring: 0 OS, 1 physical |
| cppr_wr_value | input | 8 | New CPPR value |
| ack_rdata | output | 16 | Last acknowledge result {NSR, CPPR} |
| os_irq | output | 1 | OS ring exception output |
| phys_irq | output | 1 | Physical ring exception output |
| os_cppr | output | 8 | OS CPPR |
| os_pipr | output | 8 | OS PIPR |
| os_nsr | output | 8 | OS NSR |
| phys_cppr | output | 8 | Physical CPPR |
| phys_pipr | output | 8 | Physical PIPR |
| phys_nsr | output | 8 | Physical NSR |
| os_ipb | output | 8 | OS pending buffer |
| pool_ipb | output | 8 | Pool pending buffer |
| phys_ipb | output | 8 | Physical pending buffer |

## Verification
The assertions assume that the caller never acknowledges a ring whose NSR holds a group exception while a new group presentation aims at the same ring. They also assume that pool_ctx_valid changes only between operations. The stimulus honours both assumptions: it drives every request on the falling edge, holds the pool valid flag steady for the whole of each command, and sends group presentations only to a ring after its previous exception has been acknowledged. Simultaneous requests appear only in the directed arbitration tests, where the expected outcome is that only the winning operation takes effect.

// File: rtl/tipp_pkg.sv
package tipp_pkg;
    localparam int PRIO_W   = 3;
    localparam int NPRIO    = 1 << PRIO_W;
    localparam int GRP_W    = 6;
    localparam int REG_W    = 8;
    localparam int NRING    = 3;
    localparam int NSIG     = 2;
    localparam int RING_OS   = 0;
    localparam int RING_POOL = 1;
    localparam int RING_PHYS = 2;
    localparam int SIG_OS   = 0;
    localparam int SIG_PHYS = 1;

    localparam logic [REG_W-1:0] PRIO_NONE = '1;
    localparam logic [REG_W-1:0] MAX_PRIO  = REG_W'(NPRIO - 1);
    localparam logic [1:0] CODE_OS   = 2'b10;
    localparam logic [1:0] CODE_POOL = 2'b01;
    localparam logic [1:0] CODE_PHYS = 2'b10;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_ACK     = 2'd1,
        OP_CPPR    = 2'd2,
        OP_PRESENT = 2'd3
    } op_e;

    // one-hot buffer mask for a priority; zero for out-of-range values
    function automatic logic [NPRIO-1:0] prio_bit(input logic [REG_W-1:0] p);
        prio_bit = '0;
        if (p <= MAX_PRIO)
            prio_bit = (NPRIO)'(1) << (NPRIO - 1 - int'(p));
    endfunction

    // most favoured pending priority, PRIO_NONE when the buffer is empty
    function automatic logic [REG_W-1:0] buf_to_pipr(input logic [NPRIO-1:0] b);
        buf_to_pipr = PRIO_NONE;
        for (int i = NPRIO - 1; i >= 0; i--)
            if (b[NPRIO-1-i]) buf_to_pipr = REG_W'(i);
    endfunction

    function automatic logic [REG_W-1:0] nsr_code(input logic [1:0] ring,
                                                  input logic [GRP_W-1:0] grp);
        unique case (ring)
            2'd0:    nsr_code = {CODE_OS, grp};
            2'd1:    nsr_code = {CODE_POOL, grp};
            default: nsr_code = {CODE_PHYS, grp};
        endcase
    endfunction
endpackage

// File: rtl/tipp_op_select.sv
module tipp_op_select
    import tipp_pkg::*;
(
    input  logic       ack_valid,
    input  logic       cppr_valid,
    input  logic       pres_valid,
    input  logic [1:0] pres_ring,
    output op_e        op
);
    logic [2:0] req;

    always_comb begin
        req = {ack_valid, cppr_valid, pres_valid && (pres_ring != 2'd3)};
        unique casez (req)
            3'b1??:  op = OP_ACK;
            3'b01?:  op = OP_CPPR;
            3'b001:  op = OP_PRESENT;
            default: op = OP_IDLE;
        endcase
    end
endmodule

// File: rtl/tipp_pend_bank.sv
module tipp_pend_bank
    import tipp_pkg::*;
#(
    parameter int RINGS = NRING
)(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [RINGS-1:0][NPRIO-1:0]  set_m,
    input  logic [RINGS-1:0][NPRIO-1:0]  clr_m,
    output logic [RINGS-1:0][NPRIO-1:0]  pend_q
);
    for (genvar g = 0; g < RINGS; g++) begin : g_ring
        logic [NPRIO-1:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= (q | set_m[g]) & ~clr_m[g];
        end

        assign pend_q[g] = q;

        AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
            (set_m[g] != '0) |=> ((q & $past(set_m[g])) == $past(set_m[g])))
            else $error("pending bit not set"); // R2

        AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_m[g] != '0) |=> ((q & $past(clr_m[g])) == '0))
            else $error("pending bit not cleared"); // R8
    end
endmodule

// File: rtl/tipp_sig_regs.sv
module tipp_sig_regs
    import tipp_pkg::*;
#(
    parameter logic [REG_W-1:0] CPPR_RST = '0,
    parameter logic [REG_W-1:0] PIPR_RST = PRIO_NONE
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [REG_W-1:0] cppr_d,
    input  logic [REG_W-1:0] pipr_d,
    input  logic [REG_W-1:0] nsr_d,
    output logic [REG_W-1:0] cppr_q,
    output logic [REG_W-1:0] pipr_q,
    output logic [REG_W-1:0] nsr_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cppr_q <= CPPR_RST;
            pipr_q <= PIPR_RST;
            nsr_q  <= '0;
        end else if (ld) begin
            cppr_q <= cppr_d;
            pipr_q <= pipr_d;
            nsr_q  <= nsr_d;
        end
    end
endmodule

// File: rtl/thread_irq_presenter.sv
module thread_irq_presenter
    import tipp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pool_ctx_valid,
    input  logic        pres_valid,
    input  logic [1:0]  pres_ring,
    input  logic [2:0]  pres_prio,
    input  logic [5:0]  pres_group,
    input  logic        ack_valid,
    input  logic        ack_sel,
    input  logic        cppr_wr_valid,
    input  logic        cppr_wr_sel,
    input  logic [7:0]  cppr_wr_value,
    output logic [15:0] ack_rdata,
    output logic        os_irq,
    output logic        phys_irq,
    output logic [7:0]  os_cppr,
    output logic [7:0]  os_pipr,
    output logic [7:0]  os_nsr,
    output logic [7:0]  phys_cppr,
    output logic [7:0]  phys_pipr,
    output logic [7:0]  phys_nsr,
    output logic [7:0]  os_ipb,
    output logic [7:0]  pool_ipb,
    output logic [7:0]  phys_ipb
);
    op_e op;

    logic [NRING-1:0][NPRIO-1:0] pend, set_m, clr_m;
    logic [NSIG-1:0][REG_W-1:0]  cppr_q, pipr_q, nsr_q;
    logic [NSIG-1:0]             sig_ld;
    logic [REG_W-1:0]            cppr_d, pipr_d, nsr_d;
    logic                        ack_ld;
    logic [2*REG_W-1:0]          ack_d;

    logic                        s;
    logic [REG_W-1:0]            p_new, own_best, pool_best, best, cap;
    logic [1:0]                  win_ring, tgt_ring;
    logic [REG_W-1:0]            cur_nsr;
    logic                        pending;

    tipp_op_select u_sel (
        .ack_valid  (ack_valid),
        .cppr_valid (cppr_wr_valid),
        .pres_valid (pres_valid),
        .pres_ring  (pres_ring),
        .op         (op)
    );

    tipp_pend_bank #(.RINGS(NRING)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_m  (set_m),
        .clr_m  (clr_m),
        .pend_q (pend)
    );

    for (genvar g = 0; g < NSIG; g++) begin : g_sig
        tipp_sig_regs u_regs (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (sig_ld[g]),
            .cppr_d (cppr_d),
            .pipr_d (pipr_d),
            .nsr_d  (nsr_d),
            .cppr_q (cppr_q[g]),
            .pipr_q (pipr_q[g]),
            .nsr_q  (nsr_q[g])
        );
    end

    always_comb begin
        set_m     = '0;
        clr_m     = '0;
        sig_ld    = '0;
        cppr_d    = '0;
        pipr_d    = '0;
        nsr_d     = '0;
        ack_ld    = 1'b0;
        ack_d     = '0;
        s         = 1'b0;
        p_new     = REG_W'(pres_prio);
        own_best  = PRIO_NONE;
        pool_best = buf_to_pipr(pend[RING_POOL]);
        best      = PRIO_NONE;
        cap       = cppr_wr_value;
        win_ring  = 2'(RING_OS);
        tgt_ring  = 2'(RING_OS);
        cur_nsr   = '0;
        pending   = 1'b0;

        unique case (op)
            OP_PRESENT: begin
                s = (pres_ring != 2'(RING_OS));
                if (pres_group == '0)
                    set_m[pres_ring] = prio_bit(p_new);
                if (pres_group != '0 || p_new < pipr_q[s]) begin
                    sig_ld[s] = 1'b1;
                    cppr_d    = cppr_q[s];
                    pipr_d    = p_new;
                    nsr_d     = (p_new < cppr_q[s]) ? nsr_code(pres_ring, pres_group) : '0;
                end
            end
            OP_CPPR: begin
                s        = cppr_wr_sel;
                cap      = (cppr_wr_value > MAX_PRIO) ? PRIO_NONE : cppr_wr_value;
                own_best = buf_to_pipr(pend[s ? RING_PHYS : RING_OS]);
                best     = own_best;
                win_ring = s ? 2'(RING_PHYS) : 2'(RING_OS);
                if (s && pool_ctx_valid && (pool_best < own_best)) begin
                    best     = pool_best;
                    win_ring = 2'(RING_POOL);
                end
                sig_ld[s] = 1'b1;
                cppr_d    = cap;
                pipr_d    = best;
                nsr_d     = (best < cap) ? nsr_code(win_ring, '0) : '0;
            end
            OP_ACK: begin
                s       = ack_sel;
                cur_nsr = nsr_q[s];
                pending = s ? (cur_nsr[7:6] != 2'b00) : cur_nsr[7];
                ack_ld  = 1'b1;
                ack_d   = {cur_nsr, cppr_q[s]};
                if (pending) begin
                    if (!s)                          tgt_ring = 2'(RING_OS);
                    else if (cur_nsr[7:6] == CODE_POOL) tgt_ring = 2'(RING_POOL);
                    else                             tgt_ring = 2'(RING_PHYS);
                    if (cur_nsr[GRP_W-1:0] == '0)
                        clr_m[tgt_ring] = prio_bit(pipr_q[s]);
                    sig_ld[s] = 1'b1;
                    cppr_d    = pipr_q[s];
                    pipr_d    = pipr_q[s];
                    nsr_d     = '0;
                    ack_d     = {cur_nsr, pipr_q[s]};
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ack_rdata <= '0;
        else if (ack_ld) ack_rdata <= ack_d;
    end

    assign os_cppr   = cppr_q[SIG_OS];
    assign os_pipr   = pipr_q[SIG_OS];
    assign os_nsr    = nsr_q[SIG_OS];
    assign phys_cppr = cppr_q[SIG_PHYS];
    assign phys_pipr = pipr_q[SIG_PHYS];
    assign phys_nsr  = nsr_q[SIG_PHYS];
    assign os_irq    = nsr_q[SIG_OS][7];
    assign phys_irq  = |nsr_q[SIG_PHYS][7:6];
    assign os_ipb    = pend[RING_OS];
    assign pool_ipb  = pend[RING_POOL];
    assign phys_ipb  = pend[RING_PHYS];

    AST_OS_IRQ_BEATS_CPPR: assert property (@(posedge clk) disable iff (!rst_n)
        os_irq |-> (os_pipr < os_cppr)) else $error("os exception without winner"); // R4

    AST_PHYS_IRQ_BEATS_CPPR: assert property (@(posedge clk) disable iff (!rst_n)
        phys_irq |-> (phys_pipr < phys_cppr)) else $error("phys exception without winner"); // R4

    AST_NSR_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (phys_nsr[7:6] != 2'b11) && !os_nsr[6]) else $error("illegal nsr code"); // R5

    AST_ACK_DROPS_OS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !ack_sel) |=> (os_nsr == '0 && !os_irq)) else $error("os ack left nsr"); // R8

    AST_ACK_DROPS_PHYS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_sel) |=> (phys_nsr == '0 && !phys_irq)) else $error("phys ack left nsr"); // R8

    AST_CPPR_CLAMP_OS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_valid && cppr_wr_valid && !cppr_wr_sel && cppr_wr_value > MAX_PRIO)
        |=> (os_cppr == PRIO_NONE)) else $error("os cppr not clamped"); // R10

    AST_CPPR_CLAMP_PHYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_valid && cppr_wr_valid && cppr_wr_sel && cppr_wr_value > MAX_PRIO)
        |=> (phys_cppr == PRIO_NONE)) else $error("phys cppr not clamped"); // R10

    AST_ACK_BLOCKS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_sel) |=> $stable(os_cppr)) else $error("lower request ran with ack"); // R12
endmodule

// File: tb/thread_irq_presenter_test.sv
`timescale 1ns/1ps
module thread_irq_presenter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pool_ctx_valid = 1'b0;
    logic        pres_valid = 1'b0;
    logic [1:0]  pres_ring = '0;
    logic [2:0]  pres_prio = '0;
    logic [5:0]  pres_group = '0;
    logic        ack_valid = 1'b0;
    logic        ack_sel = 1'b0;
    logic        cppr_wr_valid = 1'b0;
    logic        cppr_wr_sel = 1'b0;
    logic [7:0]  cppr_wr_value = '0;
    logic [15:0] ack_rdata;
    logic        os_irq, phys_irq;
    logic [7:0]  os_cppr, os_pipr, os_nsr, phys_cppr, phys_pipr, phys_nsr;
    logic [7:0]  os_ipb, pool_ipb, phys_ipb;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    thread_irq_presenter uut (
        .clk(clk), .rst_n(rst_n), .pool_ctx_valid(pool_ctx_valid),
        .pres_valid(pres_valid), .pres_ring(pres_ring), .pres_prio(pres_prio),
        .pres_group(pres_group), .ack_valid(ack_valid), .ack_sel(ack_sel),
        .cppr_wr_valid(cppr_wr_valid), .cppr_wr_sel(cppr_wr_sel),
        .cppr_wr_value(cppr_wr_value), .ack_rdata(ack_rdata),
        .os_irq(os_irq), .phys_irq(phys_irq),
        .os_cppr(os_cppr), .os_pipr(os_pipr), .os_nsr(os_nsr),
        .phys_cppr(phys_cppr), .phys_pipr(phys_pipr), .phys_nsr(phys_nsr),
        .os_ipb(os_ipb), .pool_ipb(pool_ipb), .phys_ipb(phys_ipb)
    );

    // {op(2) 0 present/1 ack/2 cppr, ring(2), pool_valid(1), prio(3), group(6), value(8),
    //  ipb ring(2), exp cppr(8), exp pipr(8), exp nsr(8), exp ipb(8), exp ack(16)}
    localparam int NV = 24;
    localparam logic [71:0] VECS [NV] = '{
        {2'd2,2'd0,1'b0,3'd0,6'd0,8'h05, 2'd0,8'h05,8'hFF,8'h00,8'h00,16'h0000}, // R10 empty buffer
        {2'd0,2'd0,1'b0,3'd3,6'd0,8'h00, 2'd0,8'h05,8'h03,8'h80,8'h10,16'h0000}, // R2 R3 R4 R5
        {2'd0,2'd0,1'b0,3'd6,6'd0,8'h00, 2'd0,8'h05,8'h03,8'h80,8'h12,16'h0000}, // R2 R3 bit only
        {2'd1,2'd0,1'b0,3'd0,6'd0,8'h00, 2'd0,8'h03,8'h03,8'h00,8'h02,16'h8003}, // R8
        {2'd1,2'd0,1'b0,3'd0,6'd0,8'h00, 2'd0,8'h03,8'h03,8'h00,8'h02,16'h0003}, // R9
        {2'd2,2'd0,1'b0,3'd0,6'd0,8'h07, 2'd0,8'h07,8'h06,8'h80,8'h02,16'h0000}, // R10 rerun check
        {2'd2,2'd0,1'b0,3'd0,6'd0,8'h09, 2'd0,8'hFF,8'h06,8'h80,8'h02,16'h0000}, // R10 clamp
        {2'd1,2'd0,1'b0,3'd0,6'd0,8'h00, 2'd0,8'h06,8'h06,8'h00,8'h00,16'h8006}, // R8
        {2'd0,2'd0,1'b0,3'd2,6'd5,8'h00, 2'd0,8'h06,8'h02,8'h85,8'h00,16'h0000}, // R7 R5 group
        {2'd1,2'd0,1'b0,3'd0,6'd0,8'h00, 2'd0,8'h02,8'h02,8'h00,8'h00,16'h8502}, // R8 group keeps buffer
        {2'd0,2'd0,1'b0,3'd4,6'd1,8'h00, 2'd0,8'h02,8'h04,8'h00,8'h00,16'h0000}, // R7 R4 no win
        {2'd0,2'd2,1'b0,3'd1,6'd0,8'h00, 2'd2,8'h00,8'h01,8'h00,8'h40,16'h0000}, // R4 cppr 0 blocks
        {2'd2,2'd2,1'b0,3'd0,6'd0,8'h04, 2'd2,8'h04,8'h01,8'h80,8'h40,16'h0000}, // R5 R10 phys code
        {2'd0,2'd1,1'b0,3'd0,6'd0,8'h00, 2'd1,8'h04,8'h00,8'h40,8'h80,16'h0000}, // R6 R5 pool code
        {2'd1,2'd2,1'b0,3'd0,6'd0,8'h00, 2'd1,8'h00,8'h00,8'h00,8'h00,16'h4000}, // R8 R6 pool bit cleared
        {2'd0,2'd1,1'b0,3'd0,6'd0,8'h00, 2'd1,8'h00,8'h00,8'h00,8'h80,16'h0000}, // R3 R6 equal pipr
        {2'd2,2'd2,1'b0,3'd0,6'd0,8'h06, 2'd1,8'h06,8'h01,8'h80,8'h80,16'h0000}, // R11 pool ignored
        {2'd2,2'd2,1'b1,3'd0,6'd0,8'h06, 2'd1,8'h06,8'h00,8'h40,8'h80,16'h0000}, // R11 pool wins
        {2'd1,2'd2,1'b0,3'd0,6'd0,8'h00, 2'd1,8'h00,8'h00,8'h00,8'h00,16'h4000}, // R8 R11
        {2'd2,2'd2,1'b1,3'd0,6'd0,8'h05, 2'd2,8'h05,8'h01,8'h80,8'h40,16'h0000}, // R11 pool empty
        {2'd1,2'd2,1'b0,3'd0,6'd0,8'h00, 2'd2,8'h01,8'h01,8'h00,8'h00,16'h8001}, // R8 phys bit cleared
        {2'd0,2'd2,1'b0,3'd3,6'd0,8'h00, 2'd2,8'h01,8'h01,8'h00,8'h10,16'h0000}, // R3 phys bit only
        {2'd0,2'd1,1'b0,3'd3,6'd0,8'h00, 2'd1,8'h01,8'h01,8'h00,8'h10,16'h0000}, // R3 R6 pool bit only
        {2'd2,2'd2,1'b1,3'd0,6'd0,8'h07, 2'd1,8'h07,8'h03,8'h80,8'h10,16'h0000}  // R11 tie stays phys
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        pres_valid    = 1'b0;
        ack_valid     = 1'b0;
        cppr_wr_valid = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #(20 * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 os_cppr", 16'(os_cppr), 16'h00);
        chk("R1 os_pipr", 16'(os_pipr), 16'hFF);
        chk("R1 phys_pipr", 16'(phys_pipr), 16'hFF);
        chk("R1 nsr pair", {os_nsr, phys_nsr}, 16'h0000);
        chk("R1 buffers", 16'({os_ipb | pool_ipb | phys_ipb}), 16'h00);
        chk("R1 irqs", 16'({os_irq, phys_irq}), 16'h0);
        chk("R1 ack_rdata", ack_rdata, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            logic [71:0] v;
            logic [7:0] a_cppr, a_pipr, a_nsr, a_ipb;
            logic a_irq;
            v = VECS[i];
            pool_ctx_valid = v[67];
            unique case (v[71:70])
                2'd0: begin
                    pres_valid = 1'b1; pres_ring = v[69:68];
                    pres_prio = v[66:64]; pres_group = v[63:58];
                end
                2'd1: begin
                    ack_valid = 1'b1; ack_sel = (v[69:68] != 2'd0);
                end
                default: begin
                    cppr_wr_valid = 1'b1; cppr_wr_sel = (v[69:68] != 2'd0);
                    cppr_wr_value = v[57:50];
                end
            endcase
            step();
            if (v[69:68] == 2'd0) begin
                a_cppr = os_cppr; a_pipr = os_pipr; a_nsr = os_nsr; a_irq = os_irq;
            end else begin
                a_cppr = phys_cppr; a_pipr = phys_pipr; a_nsr = phys_nsr; a_irq = phys_irq;
            end
            a_ipb = (v[49:48] == 2'd0) ? os_ipb : (v[49:48] == 2'd1) ? pool_ipb : phys_ipb;
            chk($sformatf("vector %0d cppr (R4 R8 R10)", i), 16'(a_cppr), 16'(v[47:40]));
            chk($sformatf("vector %0d pipr (R3 R10 R11)", i), 16'(a_pipr), 16'(v[39:32]));
            chk($sformatf("vector %0d nsr (R5 R6)", i), 16'(a_nsr), 16'(v[31:24]));
            chk($sformatf("vector %0d irq (R4)", i), 16'(a_irq), 16'(v[31:24] != 8'h00));
            chk($sformatf("vector %0d buffer (R2 R7)", i), 16'(a_ipb), 16'(v[23:16]));
            if (v[71:70] == 2'd1)
                chk($sformatf("vector %0d ack data (R8 R9)", i), ack_rdata, v[15:0]);
        end

        // R12: ack, CPPR write and presentation together; only the ack runs
        pool_ctx_valid = 1'b0;
        ack_valid = 1'b1; ack_sel = 1'b1;
        cppr_wr_valid = 1'b1; cppr_wr_sel = 1'b0; cppr_wr_value = 8'h00;
        pres_valid = 1'b1; pres_ring = 2'd0; pres_prio = 3'd0; pres_group = 6'd0;
        step();
        chk("R12 ack ran phys_cppr", 16'(phys_cppr), 16'h03);
        chk("R12 ack ran phys_ipb", 16'(phys_ipb), 16'h00);
        chk("R12 ack data", ack_rdata, 16'h8003);
        chk("R12 phys_irq low", 16'(phys_irq), 16'h0);
        chk("R12 cppr write dropped", 16'(os_cppr), 16'h02);
        chk("R12 presentation dropped", 16'(os_ipb), 16'h00);

        // R12: CPPR write beats presentation
        cppr_wr_valid = 1'b1; cppr_wr_sel = 1'b0; cppr_wr_value = 8'h07;
        pres_valid = 1'b1; pres_ring = 2'd0; pres_prio = 3'd1; pres_group = 6'd0;
        step();
        chk("R12 cppr write ran", 16'(os_cppr), 16'h07);
        chk("R12 R10 os pipr empty", 16'(os_pipr), 16'hFF);
        chk("R12 os nsr", 16'(os_nsr), 16'h00);
        chk("R12 presentation dropped under cppr", 16'(os_ipb), 16'h00);

        // R12: reserved ring code is dropped
        pres_valid = 1'b1; pres_ring = 2'd3; pres_prio = 3'd0; pres_group = 6'd0;
        step();
        chk("R12 reserved ring buffers", {os_ipb, phys_ipb}, 16'h0000);
        chk("R12 reserved ring pool", 16'(pool_ipb), 16'h10);
        chk("R12 reserved ring nsr", {os_nsr, phys_nsr}, 16'h0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule